// File: doc/BRIEF.md
# Serial Flash Page-Write Slave

This block is the device end of a small serial flash. It listens on a four-wire SPI link in mode 0 and accepts three commands: set the write-enable latch, read the status byte, and program one page. The SPI pins are sampled in the system clock domain, so SCK must run several times slower than `clk`. A page-program frame fills a 256-entry staging buffer. A per-entry valid bit records which offsets the frame touched. When chip select rises on a clean byte boundary, a self-timed write cycle copies only the touched entries into the on-chip array. The other bytes of the page keep their old contents.

The byte pointer wraps inside the addressed page. Once more than a page of data has arrived, later bytes overwrite earlier ones, so the final page-worth of bytes is what gets written. A host polls the status byte to learn when the cycle is over. A separate synchronous read port on the array lets the surrounding logic see the stored bytes. An active-low reset aborts a running cycle. After reset, the device ignores chip select for a fixed recovery interval.

Top module: `pgw_flash_slave`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch. Opcode 0x05 shifts out the status byte {6'b0, WEL, WIP}, MSB first, with WIP in bit 0 and WEL in bit 1. MISO changes on falling SCK, and the byte is re-sent for as long as chip select stays low.
- R2: A program frame is opcode 0x0A, then three address bytes sent MSB first, then data bytes. The page is given by address bits [9:8] and the offset by bits [7:0].
- R3: A program frame sent while WEL is 0 has no effect: the array is unchanged and WIP stays 0.
- R4: Data that runs past offset 255 continues at offset 0 of the same page.
- R5: When more than 256 data bytes arrive, only the last 256 are written.
- R6: Bytes of the page that the frame did not address keep their contents.
- R7: If chip select rises while a byte is partly shifted in, or before any data byte, the frame is discarded and no write cycle starts.
- R8: WIP is 1 for WRITE_CYCLES clocks from the rise of chip select and then returns to 0. WEL is 0 throughout the cycle.
- R9: A program frame aimed at a page whose `page_lock` bit is 1 is not executed.
- R10: While a cycle runs, program and write-enable commands are ignored and the running cycle is undisturbed.
- R11: Reset clears WIP and WEL and aborts any running cycle. A frame that begins within RECOVERY_CYCLES clocks after reset is released is ignored.
- R12: Any program frame that the block accepted clears WEL when chip select rises, whether or not the write runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data into the device |
| page_lock | input | PAGES | One protect bit per page |
| rd_addr | input | PG_W+8 | Array read address {page, offset} |
| miso | output | 1 | Serial data out of the device |
| rd_data | output | 8 | Array byte, one clock after rd_addr |

## Verification
The hardest case to reach is a write command that arrives while a cycle is still running. WEL has already cleared by then, so the case can only be shown by timing. The stimulus starts a valid page write and, within the busy window, sends a write-enable and then a second program frame to the same bytes. It then confirms that WIP is still set and that the bytes hold the first frame's data. Reset recovery is reached the same way: a write-enable frame is started only a few clocks after reset is released, and the next status read must show WEL still at 0.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam logic [7:0] OPC_WEN  = 8'h06;
  localparam logic [7:0] OPC_STAT = 8'h05;
  localparam logic [7:0] OPC_PROG = 8'h0A;

  typedef enum logic [2:0] {
    FR_OPC,
    FR_ADDR,
    FR_DATA,
    FR_STAT,
    FR_SKIP
  } frame_t;
endpackage

// File: rtl/pgw_shifter.sv
module pgw_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic [2:0] bit_cnt,
  output logic       miso
);
  logic [2:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] tx_q, tx_d;
  logic       miso_q, miso_d;
  logic       done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    miso_d = miso_q;
    done_d = 1'b0;
    if (!sel) begin
      cnt_d  = '0;
      miso_d = 1'b0;
    end else begin
      if (sck_rise) begin
        sh_d   = {sh_q[6:0], mosi};
        cnt_d  = cnt_q + 3'd1;
        done_d = (cnt_q == 3'd7);
      end
      if (sck_fall) begin
        miso_d = tx_q[7];
        tx_d   = {tx_q[6:0], 1'b0};
      end
    end
    if (tx_load) tx_d = tx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      miso_q <= miso_d;
      done_q <= done_d;
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = sh_q;
  assign bit_cnt   = cnt_q;
  assign miso      = miso_q;

  // bit counter advances only on a sampled SCK rising edge
  p_cnt_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !sck_rise) |=> $stable(cnt_q));
endmodule

// File: rtl/pgw_pagebuf.sv
module pgw_pagebuf #(
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             rd_vld
);
  logic [7:0]            ent_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr) vld_d = '0;
    else if (wr_en) vld_d[wr_off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_q[wr_off] <= wr_data;
  end

  assign rd_data = ent_q[rd_off];
  assign rd_vld  = vld_q[rd_off];

  // a buffered byte marks its offset as touched
  p_fill_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> vld_q[$past(wr_off)]);
endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int PAGES = 4,
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int AW = PG_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PG_W-1:0]  page,
  input  logic [7:0]       buf_data,
  input  logic             buf_vld,
  output logic [OFF_W-1:0] scan_off,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(PAGE_BYTES - 1);

  logic [7:0]       mem_q [PAGES*PAGE_BYTES];
  logic             scan_q, scan_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [PG_W-1:0]  pg_q, pg_d;
  logic [7:0]       rd_q;

  always_comb begin
    scan_d = scan_q;
    off_d  = off_q;
    pg_d   = pg_q;
    if (start) begin
      scan_d = 1'b1;
      off_d  = '0;
      pg_d   = page;
    end else if (scan_q) begin
      off_d = off_q + OFF_W'(1);
      if (off_q == LAST) scan_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= 1'b0;
      off_q  <= '0;
      pg_q   <= '0;
    end else begin
      scan_q <= scan_d;
      off_q  <= off_d;
      pg_q   <= pg_d;
    end
  end

  always_ff @(posedge clk) begin
    if (scan_q && buf_vld) mem_q[{pg_q, off_q}] <= buf_data;
    rd_q <= mem_q[rd_addr];
  end

  assign scan_off = off_q;
  assign rd_data  = rd_q;

  // a new cycle never starts on top of a running copy
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !scan_q);
  p_page_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_q && !start) |=> $stable(pg_q));
endmodule

// File: rtl/pgw_flash_slave.sv
module pgw_flash_slave
  import pgw_pkg::*;
#(
  parameter int PAGES = 4,
  parameter int PAGE_BYTES = 256,
  parameter int WRITE_CYCLES = 300,
  parameter int RECOVERY_CYCLES = 32,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int AW = PG_W + OFF_W,
  localparam int WC_W = $clog2(WRITE_CYCLES + 1),
  localparam int RC_W = $clog2(RECOVERY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic [PAGES-1:0] page_lock,
  input  logic [AW-1:0]    rd_addr,
  output logic             miso,
  output logic [7:0]       rd_data
);
  logic sck_s, sck_d, cs_s, cs_d, mosi_s;
  logic [RC_W-1:0] rec_q, rec_d;
  logic sel_q, sel_d;
  frame_t st_q, st_d;
  logic [AW-1:0] addr_q, addr_d, addr_nx;
  logic [1:0] acnt_q, acnt_d;
  logic got_q, got_d, wel_q, wel_d, busy_q, busy_d;
  logic [WC_W-1:0] wt_q, wt_d;
  logic [OFF_W-1:0] ptr_q, ptr_d;
  logic ready, sck_rise, sck_fall, cs_fall, cs_rise;
  logic clr, bwr, tx_load, start;
  logic byte_done;
  logic [7:0] rx_byte, buf_data;
  logic [2:0] bit_cnt;
  logic buf_vld;
  logic [OFF_W-1:0] scan_off;
  logic [PG_W-1:0] page;

  assign ready    = (rec_q == '0);
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign addr_nx  = {addr_q, rx_byte}[AW-1:0];
  assign page     = addr_q[OFF_W +: PG_W];

  always_comb begin
    rec_d = rec_q;
    if (!ready) rec_d = rec_q - RC_W'(1);
    sel_d = sel_q;
    if (cs_s) sel_d = 1'b0;
    else if (cs_fall && ready) sel_d = 1'b1;
  end

  always_comb begin
    st_d = st_q;  addr_d = addr_q;  acnt_d = acnt_q;  got_d = got_q;
    wel_d = wel_q;  busy_d = busy_q;  wt_d = wt_q;  ptr_d = ptr_q;
    clr = 1'b0;  bwr = 1'b0;  tx_load = 1'b0;  start = 1'b0;
    if (busy_q) begin
      wt_d = wt_q - WC_W'(1);
      if (wt_q == WC_W'(1)) busy_d = 1'b0;
    end
    if (!sel_q) begin
      st_d = FR_OPC;
    end else if (cs_rise) begin
      st_d = FR_OPC;
      if (st_q == FR_ADDR || st_q == FR_DATA) wel_d = 1'b0;
      if (st_q == FR_DATA && got_q && bit_cnt == 3'd0 && !page_lock[page]) begin
        start  = 1'b1;
        busy_d = 1'b1;
        wt_d   = WC_W'(WRITE_CYCLES);
      end
    end else if (byte_done) begin
      unique case (st_q)
        FR_OPC: begin
          st_d = FR_SKIP;
          if (rx_byte == OPC_WEN) begin
            if (!busy_q) wel_d = 1'b1;
          end else if (rx_byte == OPC_STAT) begin
            tx_load = 1'b1;
            st_d    = FR_STAT;
          end else if (rx_byte == OPC_PROG && wel_q && !busy_q) begin
            st_d   = FR_ADDR;
            acnt_d = '0;
            got_d  = 1'b0;
            clr    = 1'b1;
          end
        end
        FR_ADDR: begin
          addr_d = addr_nx;
          acnt_d = acnt_q + 2'd1;
          if (acnt_q == 2'd2) begin
            st_d  = FR_DATA;
            ptr_d = addr_nx[OFF_W-1:0];
          end
        end
        FR_DATA: begin
          bwr   = 1'b1;
          ptr_d = ptr_q + OFF_W'(1);
          got_d = 1'b1;
        end
        FR_STAT: tx_load = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= 1'b0;  sck_d <= 1'b0;  cs_s <= 1'b1;  cs_d <= 1'b1;  mosi_s <= 1'b0;
      rec_q <= RC_W'(RECOVERY_CYCLES);
      sel_q <= 1'b0;  st_q <= FR_OPC;  addr_q <= '0;  acnt_q <= '0;
      got_q <= 1'b0;  wel_q <= 1'b0;  busy_q <= 1'b0;  wt_q <= '0;  ptr_q <= '0;
    end else begin
      sck_s <= sck;  sck_d <= sck_s;  cs_s <= cs_n;  cs_d <= cs_s;  mosi_s <= mosi;
      rec_q <= rec_d;
      sel_q <= sel_d;  st_q <= st_d;  addr_q <= addr_d;  acnt_q <= acnt_d;
      got_q <= got_d;  wel_q <= wel_d;  busy_q <= busy_d;  wt_q <= wt_d;  ptr_q <= ptr_d;
    end
  end

  pgw_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi(mosi_s), .tx_load(tx_load), .tx_byte({6'b0, wel_q, busy_q}),
    .byte_done(byte_done), .rx_byte(rx_byte), .bit_cnt(bit_cnt), .miso(miso)
  );

  pgw_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(bwr), .wr_off(ptr_q),
    .wr_data(rx_byte), .rd_off(scan_off), .rd_data(buf_data), .rd_vld(buf_vld)
  );

  pgw_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_arr (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .buf_data(buf_data),
    .buf_vld(buf_vld), .scan_off(scan_off), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // WIP stays up until its count runs out
  p_busy_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wt_q > WC_W'(1)) |=> busy_q);
  // the latch is never set while a cycle runs
  p_wel_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !wel_q);
  // a cycle only starts on a whole-byte boundary
  p_start_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (bit_cnt == 3'd0));
  // no frame is accepted during reset recovery
  p_recovery_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !sel_q);
endmodule

// File: tb/pgw_flash_slave_bench.sv
module pgw_flash_slave_bench;
  localparam int PAGES = 4;
  localparam int WCYC  = 300;
  localparam int RCYC  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [PAGES-1:0] page_lock = '0;
  logic [9:0] rd_addr = '0;
  logic miso;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  pgw_flash_slave #(.PAGES(PAGES), .PAGE_BYTES(256), .WRITE_CYCLES(WCYC),
                    .RECOVERY_CYCLES(RCYC)) u_pgw_flash_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .page_lock(page_lock), .rd_addr(rd_addr), .miso(miso), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [PAGES*256];
  int   exp_q [$];
  string tag_q [$];
  int   obs_val = 0;
  logic obs_stb = 1'b0;
  bit   finished = 1'b0;

  // monitor: pops expected items and compares them as results appear
  initial begin
    forever begin
      @(posedge obs_stb);
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected result %0d", obs_val);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (obs_val != e) begin
          errors++;
          $display("FAIL %s: got 0x%0h expected 0x%0h", t, obs_val, e);
        end
      end
    end
  end

  task automatic expect_item(input string t, input int v);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic observe(input int v);
    obs_val = v;
    obs_stb = 1'b1;
    @(negedge clk);
    obs_stb = 1'b0;
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      clks(3);
      r = {r[6:0], miso};
      sck = 1'b1;
      clks(3);
      sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] b);
    logic [7:0] r;
    spi_bits(b, 8, r);
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    clks(3);
  endtask

  task automatic sel_off();
    clks(3);
    cs_n = 1'b1;
    clks(6);
  endtask

  function automatic logic [7:0] dbyte(input int seed, input int i);
    return 8'((seed + i * 37 + (i >> 8) * 101) & 255);
  endfunction

  task automatic wren();
    sel_on(); spi_byte(8'h06); sel_off();
  endtask

  task automatic status_check(input string t, input int exp_v, input int reps);
    logic [7:0] r;
    sel_on();
    spi_byte(8'h05);
    for (int k = 0; k < reps; k++) begin
      spi_bits(8'h00, 8, r);
      expect_item(t, exp_v);
      observe(int'(r));
    end
    sel_off();
  endtask

  task automatic prog(input int pg, input int off, input int n, input int seed,
                      input int extra);
    logic [9:0]  a;
    logic [7:0]  r;
    a = 10'(pg * 256 + off);
    sel_on();
    spi_byte(8'h0A);
    spi_byte(8'h00);
    spi_byte({6'b0, a[9:8]});
    spi_byte(a[7:0]);
    for (int i = 0; i < n; i++) spi_byte(dbyte(seed, i));
    if (extra > 0) spi_bits(8'hFF, extra, r);
    sel_off();
  endtask

  function automatic void model_apply(input int pg, input int off, input int n,
                                      input int seed);
    for (int i = 0; i < n; i++)
      model[pg * 256 + ((off + i) % 256)] = dbyte(seed, i);
  endfunction

  task automatic check_mem(input string t, input int pg, input int off, input int n);
    for (int i = 0; i < n; i++) begin
      rd_addr = 10'(pg * 256 + ((off + i) % 256));
      @(negedge clk);
      expect_item(t, int'(model[pg * 256 + ((off + i) % 256)]));
      observe(int'(rd_data));
    end
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clks(3);
    rst_n = 1'b1;
    clks(RCYC + 4);

    // R11 / R1: reset state, then the latch through status
    status_check("R11 reset status", 8'h00, 1);
    if (miso !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle miso: got %b expected 0", miso);
    end
    checks++;
    wren();
    status_check("R1 status repeats with WEL", 8'h02, 2);

    // R2 / R8: fill pages 0 and 1 completely
    prog(0, 0, 256, 11, 0);
    model_apply(0, 0, 256, 11);
    status_check("R8 WIP set WEL clear", 8'h01, 1);
    clks(WCYC + 20);
    status_check("R8 WIP returns low", 8'h00, 1);
    wren();
    prog(1, 0, 256, 77, 0);
    model_apply(1, 0, 256, 77);
    clks(WCYC + 120);
    check_mem("R2 full page 0", 0, 0, 256);

    // R3: program without the latch
    prog(0, 10, 4, 200, 0);
    status_check("R3 no cycle without WEL", 8'h00, 1);
    check_mem("R3 page 0 unchanged", 0, 10, 4);

    // R4 and R6: wrap inside page 1
    wren();
    prog(1, 250, 10, 200, 0);
    model_apply(1, 250, 10, 200);
    clks(WCYC + 120);
    check_mem("R4 R6 wrap and untouched bytes", 1, 0, 256);

    // R5: 300 bytes into page 2, last 256 kept
    wren();
    prog(2, 5, 300, 3, 0);
    model_apply(2, 5, 300, 3);
    clks(WCYC + 120);
    check_mem("R5 overflow keeps last 256", 2, 0, 256);

    // R7 / R12: chip select rises mid-byte, and before any data
    wren();
    prog(0, 0, 3, 150, 5);
    status_check("R7 R12 mid-byte abort", 8'h00, 1);
    check_mem("R7 page 0 unchanged", 0, 0, 4);
    wren();
    prog(0, 0, 0, 150, 0);
    status_check("R7 no data byte", 8'h00, 1);

    // R9: protected page
    page_lock = 4'b0010;
    wren();
    prog(1, 0, 4, 9, 0);
    status_check("R9 R12 locked page", 8'h00, 1);
    check_mem("R9 page 1 unchanged", 1, 0, 4);
    page_lock = '0;

    // R10: commands while busy
    wren();
    prog(0, 100, 4, 50, 0);
    model_apply(0, 100, 4, 50);
    wren();
    status_check("R10 WREN ignored while busy", 8'h01, 1);
    prog(0, 100, 4, 99, 0);
    clks(WCYC + 20);
    check_mem("R10 running cycle kept", 0, 100, 4);

    // R11: reset aborts a cycle; early frame ignored
    wren();
    prog(3, 0, 2, 1, 0);
    clks(20);
    rst_n = 1'b0;
    clks(2);
    rst_n = 1'b1;
    wren();
    clks(RCYC);
    status_check("R11 abort and recovery", 8'h00, 1);
    wren();
    status_check("R11 ready after recovery", 8'h02, 1);

    clks(10);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule